// File: doc/BRIEF.md
# Pairwise-Product Vector Accumulator

This engine turns a flat stream of signed 32-bit words into per-vector sums of adjacent-pair products. A host first writes the input words into a local store through a word write port. The engine then walks that store two words at a time. It multiplies each pair and adds the product to a running sum. Once the pairs of one vector have all been taken, the sum is written into an output store, which the host reads back through a registered read port.

The run is set by three configuration inputs: vector length in words, number of vectors, and number of batch items. A `start` pulse checks the settings, latches them and opens the first batch item. For each item, the host fills the input store and pulses `load_go`. The engine computes every vector of that item and signals completion. It then waits for the next fill, or ends the run with `done` after the last item. The input store is walked in fixed-size chunks, and the running sum carries across chunk boundaries.

Top module: `pp_acc_engine`

## Requirements
- R1: After reset, `busy`, `done`, `item_done` and `cfg_err` are all low.
- R2: For vector j (0 ≤ j < vector count), output slot j holds the sum over k of x[j·L+2k]·x[j·L+2k+1], where L is the vector length and x[a] is the input word at address a.
- R3: Input word a is written by `in_we` with `in_addr`=a and `in_data`. One batch item uses words 0 to L·count−1 and fills slots 0 to count−1. Host writes are made only while the engine is not computing.
- R4: The input is scanned in chunks of CHUNK words. The last chunk of an item is shortened to the words left. A vector that straddles a chunk boundary still yields one unbroken sum.
- R5: Products and sums are two's-complement 32-bit and wrap modulo 2^32 on overflow.
- R6: A `start` in idle is rejected if the length is zero, odd or above MAX_LEN, the count is zero or above MAX_VEC, or the batch count is zero or above MAX_BATCH. On rejection, `cfg_err` is high from the next cycle and `busy` stays low. An accepted `start` clears `cfg_err`.
- R7: While `busy` is high, `start` and the configuration inputs have no effect on the run in progress.
- R8: After an accepted `start`, the engine waits for `load_go` before each batch item. It pulses `item_done` after every item but the last, and `done` after the last item. `busy` is low from the cycle `done` is high.
- R9: `out_data` shows the slot addressed by `out_addr` one clock earlier.
- R10: `done` and `item_done` each last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | LEN_W | Vector length in words |
| cfg_vec | input | VEC_W | Number of vectors per batch item |
| cfg_batch | input | BAT_W | Number of batch items |
| start | input | 1 | Begin a run (checked in idle only) |
| load_go | input | 1 | Input store is filled for the current item |
| in_we | input | 1 | Input store write enable |
| in_addr | input | IN_AW | Input word address |
| in_data | input | 32 | Input word |
| out_addr | input | OUT_AW | Output slot to read |
| out_data | output | 32 | Registered slot contents |
| busy | output | 1 | Run in progress |
| cfg_err | output | 1 | Last start was rejected |
| item_done | output | 1 | One-cycle pulse after a non-final item |
| done | output | 1 | One-cycle pulse after the final item |

## Verification
A vector commit can fall in the same cycle as a chunk rollover: the pair that closes a vector can also be the last pair of a chunk, or even the last pair of the item. The bench uses a chunk of six words and sweeps every legal even length against every vector count, so chunk ends land sometimes on a vector end and sometimes inside a vector. Each output slot is judged against a sum of pair products that the bench computes from the words it wrote.

// File: rtl/pp_acc_pkg.sv
package pp_acc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

  localparam int WORD_W = 32;

endpackage

// File: rtl/pp_acc_pair_mem.sv
module pp_acc_pair_mem #(
  parameter int PAIRS = 1024,
  parameter int IN_AW = 11,
  localparam int PAW = IN_AW - 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IN_AW-1:0] waddr,
  input  logic [31:0]      wdata,
  input  logic             re,
  input  logic [PAW-1:0]   raddr,
  output logic [31:0]      rd_even,
  output logic [31:0]      rd_odd
);

  logic [31:0] q [2];

  // Two banks: even word addresses in bank 0, odd in bank 1.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [31:0] store [PAIRS];
    always_ff @(posedge clk) begin
      if (we && (waddr[0] == b[0]) && (32'(waddr[IN_AW-1:1]) < PAIRS))
        store[waddr[IN_AW-1:1]] <= wdata;
      if (re)
        q[b] <= store[raddr];
    end
  end

  assign rd_even = q[0];
  assign rd_odd  = q[1];

endmodule

// File: rtl/pp_acc_scan.sv
module pp_acc_scan #(
  parameter int MAX_LEN = 64,
  parameter int MAX_VEC = 32,
  parameter int CHUNK   = 512,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int HL_W   = LEN_W - 1,
  localparam int VEC_W  = $clog2(MAX_VEC + 1),
  localparam int PAIRS  = (MAX_LEN * MAX_VEC) / 2,
  localparam int P_W    = $clog2(PAIRS + 1),
  localparam int PAW    = $clog2(PAIRS),
  localparam int OUT_AW = $clog2(MAX_VEC),
  localparam int CP     = CHUNK / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [HL_W-1:0]   hlen,
  input  logic [VEC_W-1:0]  vec,
  output logic              rd_en,
  output logic [PAW-1:0]    rd_pair,
  output logic              tag_valid,
  output logic              tag_last,
  output logic              tag_final,
  output logic [OUT_AW-1:0] tag_vidx
);

  logic              active;
  logic [P_W-1:0]    base, idx, clen, rem, tot;
  logic [HL_W-1:0]   pos;
  logic [OUT_AW-1:0] vidx;
  logic              last_c, chunk_end_c, final_c;

  function automatic logic [P_W-1:0] take(input logic [P_W-1:0] r);
    return (r > P_W'(CP)) ? P_W'(CP) : r;
  endfunction

  assign tot         = P_W'(hlen) * P_W'(vec);
  assign last_c      = ((HL_W+1)'(pos) + 1'b1) == (HL_W+1)'(hlen);
  assign chunk_end_c = (idx + 1'b1) == clen;
  assign final_c     = chunk_end_c && (rem == clen);
  assign rd_en       = active;
  assign rd_pair     = PAW'(base + idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      base      <= '0;
      idx       <= '0;
      clen      <= '0;
      rem       <= '0;
      pos       <= '0;
      vidx      <= '0;
      tag_valid <= 1'b0;
      tag_last  <= 1'b0;
      tag_final <= 1'b0;
      tag_vidx  <= '0;
    end else begin
      tag_valid <= active;
      tag_last  <= active && last_c;
      tag_final <= active && final_c;
      tag_vidx  <= vidx;
      if (go) begin
        active <= 1'b1;
        base   <= '0;
        idx    <= '0;
        rem    <= tot;
        clen   <= take(tot);
        pos    <= '0;
        vidx   <= '0;
      end else if (active) begin
        pos <= last_c ? '0 : pos + 1'b1;
        if (last_c) vidx <= vidx + 1'b1;
        if (chunk_end_c) begin
          base <= base + clen;
          idx  <= '0;
          rem  <= rem - clen;
          clen <= take(rem - clen);
          if (rem == clen) active <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R3
  vidx_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (32'(vidx) < 32'(vec)));

  // R4
  chunk_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx < clen));

endmodule

// File: rtl/pp_acc_accum.sv
module pp_acc_accum #(
  parameter int MAX_VEC = 32,
  localparam int OUT_AW = $clog2(MAX_VEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tag_valid,
  input  logic              tag_last,
  input  logic              tag_final,
  input  logic [OUT_AW-1:0] tag_vidx,
  input  logic [31:0]       op_a,
  input  logic [31:0]       op_b,
  input  logic [OUT_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              final_done
);

  logic signed [31:0] acc, prod, sum;
  logic [31:0]        omem [MAX_VEC];

  assign prod = $signed(op_a) * $signed(op_b);
  assign sum  = acc + prod;

  always_ff @(posedge clk) begin
    if (tag_valid && tag_last && (32'(tag_vidx) < MAX_VEC))
      omem[tag_vidx] <= sum;
    rd_data <= omem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      final_done <= 1'b0;
    end else begin
      final_done <= tag_valid && tag_final;
      if (tag_valid) acc <= tag_last ? '0 : sum;
    end
  end

  // R2
  final_is_last_chk: assert property (@(posedge clk) disable iff (rst)
    tag_final |-> (tag_valid && tag_last));

  // R10
  final_once_chk: assert property (@(posedge clk) disable iff (rst)
    final_done |=> !final_done);

endmodule

// File: rtl/pp_acc_engine.sv
module pp_acc_engine
  import pp_acc_pkg::*;
#(
  parameter int MAX_LEN   = 64,
  parameter int MAX_VEC   = 32,
  parameter int MAX_BATCH = 16,
  parameter int CHUNK     = 512,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int HL_W     = LEN_W - 1,
  localparam int VEC_W    = $clog2(MAX_VEC + 1),
  localparam int BAT_W    = $clog2(MAX_BATCH + 1),
  localparam int IN_WORDS = MAX_LEN * MAX_VEC,
  localparam int IN_AW    = $clog2(IN_WORDS),
  localparam int PAIRS    = IN_WORDS / 2,
  localparam int PAW      = $clog2(PAIRS),
  localparam int OUT_AW   = $clog2(MAX_VEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [VEC_W-1:0]  cfg_vec,
  input  logic [BAT_W-1:0]  cfg_batch,
  input  logic              start,
  input  logic              load_go,
  input  logic              in_we,
  input  logic [IN_AW-1:0]  in_addr,
  input  logic [31:0]       in_data,
  input  logic [OUT_AW-1:0] out_addr,
  output logic [31:0]       out_data,
  output logic              busy,
  output logic              cfg_err,
  output logic              item_done,
  output logic              done
);

  seq_state_t        state;
  logic [HL_W-1:0]   hlen_q;
  logic [VEC_W-1:0]  vec_q;
  logic [BAT_W-1:0]  bat_q, bidx;
  logic              cfg_ok, go, final_done;
  logic              rd_en, tag_valid, tag_last, tag_final;
  logic [PAW-1:0]    rd_pair;
  logic [OUT_AW-1:0] tag_vidx;
  logic [31:0]       rd_even, rd_odd;

  assign cfg_ok = (cfg_len != '0) && !cfg_len[0] && (cfg_len <= LEN_W'(MAX_LEN)) &&
                  (cfg_vec != '0) && (cfg_vec <= VEC_W'(MAX_VEC)) &&
                  (cfg_batch != '0) && (cfg_batch <= BAT_W'(MAX_BATCH));
  assign go   = (state == ST_LOAD) && load_go;
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hlen_q    <= '0;
      vec_q     <= '0;
      bat_q     <= '0;
      bidx      <= '0;
      cfg_err   <= 1'b0;
      item_done <= 1'b0;
      done      <= 1'b0;
    end else begin
      item_done <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cfg_err <= !cfg_ok;
          if (cfg_ok) begin
            hlen_q <= cfg_len[LEN_W-1:1];
            vec_q  <= cfg_vec;
            bat_q  <= cfg_batch;
            bidx   <= '0;
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: if (load_go) state <= ST_RUN;
        ST_RUN: if (final_done) begin
          if ((BAT_W+1)'(bidx) + 1'b1 == (BAT_W+1)'(bat_q)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            item_done <= 1'b1;
            bidx      <= bidx + 1'b1;
            state     <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pp_acc_pair_mem #(.PAIRS(PAIRS), .IN_AW(IN_AW)) u_inmem (
    .clk(clk), .we(in_we), .waddr(in_addr), .wdata(in_data),
    .re(rd_en), .raddr(rd_pair), .rd_even(rd_even), .rd_odd(rd_odd)
  );

  pp_acc_scan #(.MAX_LEN(MAX_LEN), .MAX_VEC(MAX_VEC), .CHUNK(CHUNK)) u_scan (
    .clk(clk), .rst(rst), .go(go), .hlen(hlen_q), .vec(vec_q),
    .rd_en(rd_en), .rd_pair(rd_pair), .tag_valid(tag_valid),
    .tag_last(tag_last), .tag_final(tag_final), .tag_vidx(tag_vidx)
  );

  pp_acc_accum #(.MAX_VEC(MAX_VEC)) u_accum (
    .clk(clk), .rst(rst), .tag_valid(tag_valid), .tag_last(tag_last),
    .tag_final(tag_final), .tag_vidx(tag_vidx), .op_a(rd_even), .op_b(rd_odd),
    .rd_addr(out_addr), .rd_data(out_data), .final_done(final_done)
  );

  // R6
  bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !cfg_ok) |=> (cfg_err && !busy));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(hlen_q) && $stable(vec_q) && $stable(bat_q)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || item_done) |=> !(done || item_done));

endmodule

// File: tb/pp_acc_engine_test.sv
`timescale 1ns/1ps
module pp_acc_engine_test;

  localparam int ML = 8, MV = 6, MB = 3, CH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_len = '0;
  logic [2:0]  cfg_vec = '0;
  logic [1:0]  cfg_batch = '0;
  logic        start = 1'b0, load_go = 1'b0, in_we = 1'b0;
  logic [5:0]  in_addr = '0;
  logic [31:0] in_data = '0;
  logic [2:0]  out_addr = '0;
  logic [31:0] out_data;
  logic        busy, cfg_err, item_done, done;

  int checks = 0, fails = 0, cycles = 0;
  int data [48];

  always #10 clk = ~clk;

  pp_acc_engine #(.MAX_LEN(ML), .MAX_VEC(MV), .MAX_BATCH(MB), .CHUNK(CH)) uut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_vec(cfg_vec), .cfg_batch(cfg_batch),
    .start(start), .load_go(load_go), .in_we(in_we), .in_addr(in_addr),
    .in_data(in_data), .out_addr(out_addr), .out_data(out_data), .busy(busy),
    .cfg_err(cfg_err), .item_done(item_done), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int expect_sum(int j, int len);
    int s = 0;
    for (int k = 0; k < len; k += 2) s += data[j*len+k] * data[j*len+k+1];
    return s;
  endfunction

  // mode 0: (w mod vec)+item, mode 1: large signed words, mode 2: like 0 with disturbing starts
  task automatic run(int len, int vec, int batch, int mode, string req);
    @(negedge clk);
    cfg_len = 4'(len); cfg_vec = 3'(vec); cfg_batch = 2'(batch); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", {31'd0, busy}, 32'd1);
    check("R6 err cleared", {31'd0, cfg_err}, 32'd0);
    for (int b = 0; b < batch; b++) begin
      for (int w = 0; w < len*vec; w++) begin
        if (mode == 1) data[w] = (w % 2 == 1) ? -(32'sh7ffe_0001 + w*977) : (32'sh7ff0_1234 + w*31);
        else data[w] = (w % vec) + b;
        in_we = 1'b1; in_addr = 6'(w); in_data = data[w];
        @(negedge clk);
      end
      in_we = 1'b0;
      if (mode == 2) begin
        cfg_len = 4'(ML); cfg_vec = 3'(1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      load_go = 1'b1;
      if (mode == 2) start = 1'b1;
      @(negedge clk);
      load_go = 1'b0; start = 1'b0;
      begin
        int n = 0;
        while (!(done || item_done) && n < 2000) begin @(negedge clk); n++; end
      end
      if (b == batch-1) begin
        check("R8 done on last item", {30'd0, done, item_done}, 32'd2);
        @(negedge clk);
        check("R10 done one cycle", {30'd0, done, busy}, 32'd0);
      end else begin
        check("R8 item_done on item", {30'd0, done, item_done}, 32'd1);
        @(negedge clk);
        check("R10 item_done one cycle", {30'd0, item_done, busy}, 32'd1);
      end
      for (int j = 0; j < vec; j++) begin
        out_addr = 3'(j);
        @(negedge clk);
        check(req, out_data, expect_sum(j, len));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", {28'd0, busy, done, item_done, cfg_err}, 32'd0);

    // R2 sweep of all legal lengths and counts (R3 addressing)
    for (int l = 2; l <= ML; l += 2)
      for (int v = 1; v <= MV; v++)
        run(l, v, 1, 0, "R2 pair sums");

    // R4 chunk ends fall inside vectors and last chunk is short
    run(8, 5, 1, 0, "R4 chunk carry");
    run(4, 3, 1, 0, "R4 chunk boundary mid vector");
    // R5 wrap on overflow
    run(8, 6, 2, 1, "R5 wrap");
    // R8 batch of three items with distinct data
    run(6, 4, 3, 0, "R8 batch results");
    // R7 start and config changes while busy
    run(4, 3, 2, 2, "R7 ignored start");

    // R9 back-to-back reads: latency one cycle
    @(negedge clk); out_addr = 3'd2;
    @(negedge clk); check("R9 read slot 2", out_data, expect_sum(2, 4)); out_addr = 3'd0;
    @(negedge clk); check("R9 read slot 0", out_data, expect_sum(0, 4));

    // R6 rejected configurations
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      case (t)
        0: begin cfg_len = 4'd0;  cfg_vec = 3'd2; cfg_batch = 2'd1; end
        1: begin cfg_len = 4'd3;  cfg_vec = 3'd2; cfg_batch = 2'd1; end
        2: begin cfg_len = 4'd10; cfg_vec = 3'd2; cfg_batch = 2'd1; end
        3: begin cfg_len = 4'd4;  cfg_vec = 3'd0; cfg_batch = 2'd1; end
        4: begin cfg_len = 4'd4;  cfg_vec = 3'd7; cfg_batch = 2'd1; end
        default: begin cfg_len = 4'd4; cfg_vec = 3'd2; cfg_batch = 2'd0; end
      endcase
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R6 rejected start", {30'd0, cfg_err, busy}, 32'd2);
      repeat (3) @(negedge clk);
      check("R6 no run after reject", {29'd0, busy, done, item_done}, 32'd0);
    end
    // accepted start clears cfg_err
    run(2, 2, 1, 0, "R6 run after reject");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule